// File: doc/BRIEF.md
# Ternary Fraction Switch-Chain Synthesizer

This block takes a target closure probability of the form a/3^n and derives the shortest chain of random switches that produces it. Each switch closes with probability 1/3 or 2/3. The block works backward from the target. At each step it picks a join type (series or parallel) and a switch value, then shrinks the target to the probability that the rest of the chain must still provide. This needs exactly n switches after normalization, which is the least number possible for an n-digit ternary fraction.

A request is accepted on `start_i` while the block is idle. The block first strips factors of three from the numerator, lowering the level once for each factor removed. It then emits one operation per accepted handshake on a valid/ready stream. The first operation is the switch added last, and the final operation is the base switch that starts the chain. Requests that are out of range finish at once with an error flag and emit no operations.

Top module: `tri_synth`

## Requirements
- R1: After reset, `busy_o`, `op_valid_o`, `done_o` and `err_o` are all low.
- R2: Before emitting, the numerator is divided by 3 while it is divisible, and the level drops by one for each division. The number of operations emitted equals this normalized level.
- R3: With T = 3^(level-1) for the current normalized pair and level > 1, a numerator below T emits series with 1/3 (`op_join_o`=0, `op_val_o`=0). The numerator is kept.
- R4: A numerator strictly between T and 2T emits one of two operations. If odd, it emits parallel with 1/3 (`op_join_o`=1, `op_val_o`=0) and the numerator becomes (a-T)/2. If even, it emits series with 2/3 (`op_join_o`=0, `op_val_o`=1) and the numerator becomes a/2.
- R5: A numerator above 2T emits parallel with 2/3 (`op_join_o`=1, `op_val_o`=1), and the numerator becomes a-2T.
- R6: At level 1 the block emits the base switch with `op_last_o`=1 and `op_join_o`=0. `op_val_o` is 0 for numerator 1 and 1 for numerator 2.
- R7: Composing the emitted stream from the base switch outward reproduces a/3^n exactly. A series join with p gives F·p, and a parallel join with p gives p+(1-p)·F.
- R8: While `op_valid_o` is high and `op_ready_i` is low, `op_valid_o` stays high and the operation fields stay stable on the next cycle.
- R9: A request with a=0, a≥3^n, n=0 or n>MAX_LVL raises `done_o` and `err_o` together one cycle later, and emits no operation.
- R10: `done_o` is a one-cycle pulse in the cycle after the last handshake, with `busy_o` low. `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled while idle |
| num_i | input | NUM_W | Target numerator a |
| lvl_i | input | LVL_W | Target level n (denominator 3^n) |
| busy_o | output | 1 | Request in progress |
| op_valid_o | output | 1 | Operation available |
| op_ready_i | input | 1 | Consumer accepts operation |
| op_join_o | output | 1 | 0 series, 1 parallel |
| op_val_o | output | 1 | 0 switch 1/3, 1 switch 2/3 |
| op_last_o | output | 1 | Base switch, final operation |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected, valid with done_o |

## Verification
The assertions check on every cycle that a stalled operation holds its valid flag and fields, that the base switch is always a series entry, that completion is a single-cycle pulse with the engine idle, and that an error appears only together with completion. The bench scenarios cover the rest. They check that the normalized level sets the operation count and that each numerator range selects the right join and value. They also rebuild the exact rational value from the whole stream and check that a start strobe during a run changes nothing.

// File: rtl/tri_pkg.sv
package tri_pkg;
  typedef enum logic [1:0] {S_IDLE, S_NORM, S_EMIT, S_DONE} tri_state_e;

  function automatic longint unsigned pow3(int n);
    longint unsigned r = 1;
    for (int i = 0; i < n; i++) r = r * 3;
    return r;
  endfunction
endpackage

// File: rtl/tri_pow3.sv
module tri_pow3 import tri_pkg::*; #(
  parameter int MAX_LVL = 16,
  parameter int IW      = 5,
  parameter int W       = 27
) (
  input  logic [IW-1:0] idx_i,
  output logic [W-1:0]  pow_o
);
  localparam int N = 2 ** IW;
  logic [W-1:0] tbl [N];

  for (genvar g = 0; g < N; g++) begin : g_tbl
    if (g <= MAX_LVL) begin : g_val
      assign tbl[g] = W'(pow3(g));
    end else begin : g_zero
      assign tbl[g] = '0;
    end
  end

  assign pow_o = tbl[idx_i];
endmodule

// File: rtl/tri_norm.sv
module tri_norm #(
  parameter int NUM_W = 26
) (
  input  logic [NUM_W-1:0] a_i,
  output logic             div_o,
  output logic [NUM_W-1:0] quo_o
);
  logic [NUM_W-1:0] rem;
  assign rem   = a_i % NUM_W'(3);
  assign quo_o = a_i / NUM_W'(3);
  assign div_o = (rem == '0);
endmodule

// File: rtl/tri_step.sv
module tri_step #(
  parameter int NUM_W = 26
) (
  input  logic [NUM_W-1:0] a_i,
  input  logic [NUM_W:0]   t_i,
  input  logic             base_i,
  output logic             join_o,
  output logic             val_o,
  output logic [NUM_W-1:0] a_nxt_o
);
  logic [NUM_W:0] a_x, two_t;
  assign a_x   = {1'b0, a_i};
  assign two_t = t_i << 1;

  always_comb begin
    join_o  = 1'b0;
    val_o   = 1'b0;
    a_nxt_o = a_i;
    if (base_i) begin
      val_o = (a_i == NUM_W'(2));
    end else if (a_x < t_i) begin
      // 1/3 series: numerator kept
    end else if (a_x < two_t) begin
      if (a_i[0]) begin
        join_o  = 1'b1;
        a_nxt_o = NUM_W'((a_x - t_i) >> 1);
      end else begin
        val_o   = 1'b1;
        a_nxt_o = a_i >> 1;
      end
    end else begin
      join_o  = 1'b1;
      val_o   = 1'b1;
      a_nxt_o = NUM_W'(a_x - two_t);
    end
  end
endmodule

// File: rtl/tri_synth.sv
module tri_synth import tri_pkg::*; #(
  parameter  int MAX_LVL = 16,
  localparam int LVL_W   = $clog2(MAX_LVL + 1),
  localparam int NUM_W   = $clog2(pow3(MAX_LVL))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             busy_o,
  output logic             op_valid_o,
  input  logic             op_ready_i,
  output logic             op_join_o,
  output logic             op_val_o,
  output logic             op_last_o,
  output logic             done_o,
  output logic             err_o
);
  tri_state_e       state_q;
  logic [NUM_W-1:0] a_q;
  logic [LVL_W-1:0] n_q;
  logic             err_q;

  logic [NUM_W:0]   lim, t;
  logic             bad_req, div3, base;
  logic [NUM_W-1:0] quo, a_nxt;

  tri_pow3 #(.MAX_LVL(MAX_LVL), .IW(LVL_W), .W(NUM_W+1)) u_pow_in (
    .idx_i(lvl_i), .pow_o(lim)
  );
  tri_pow3 #(.MAX_LVL(MAX_LVL), .IW(LVL_W), .W(NUM_W+1)) u_pow_t (
    .idx_i(n_q - LVL_W'(1)), .pow_o(t)
  );
  tri_norm #(.NUM_W(NUM_W)) u_norm (.a_i(a_q), .div_o(div3), .quo_o(quo));

  assign base = (n_q == LVL_W'(1));
  tri_step #(.NUM_W(NUM_W)) u_step (
    .a_i(a_q), .t_i(t), .base_i(base),
    .join_o(op_join_o), .val_o(op_val_o), .a_nxt_o(a_nxt)
  );

  assign bad_req = (num_i == '0) || (lvl_i == '0) ||
                   (lvl_i > LVL_W'(MAX_LVL)) || ({1'b0, num_i} >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      a_q     <= '0;
      n_q     <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          err_q <= bad_req;
          if (bad_req) state_q <= S_DONE;
          else begin
            a_q     <= num_i;
            n_q     <= lvl_i;
            state_q <= S_NORM;
          end
        end
        S_NORM: if (div3) begin
          a_q <= quo;
          n_q <= n_q - LVL_W'(1);
        end else state_q <= S_EMIT;
        S_EMIT: if (op_ready_i) begin
          if (base) state_q <= S_DONE;
          else begin
            a_q <= a_nxt;
            n_q <= n_q - LVL_W'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == S_NORM) || (state_q == S_EMIT);
  assign op_valid_o = (state_q == S_EMIT);
  assign op_last_o  = op_valid_o && base;
  assign done_o     = (state_q == S_DONE);
  assign err_o      = done_o && err_q;
endmodule

// File: rtl/tri_synth_chk.sv
module tri_synth_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic op_valid_o,
  input logic op_ready_i,
  input logic op_join_o,
  input logic op_val_o,
  input logic op_last_o,
  input logic done_o,
  input logic err_o
);
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && !op_ready_i |=> op_valid_o && $stable(op_join_o) &&
    $stable(op_val_o) && $stable(op_last_o)); // R8
  AST_BASE_SERIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_last_o |-> !op_join_o); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !op_valid_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R9
  AST_LAST_THEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_ready_i && op_last_o |=> done_o && !err_o); // R10
endmodule

bind tri_synth tri_synth_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .op_valid_o(op_valid_o),
  .op_ready_i(op_ready_i), .op_join_o(op_join_o), .op_val_o(op_val_o),
  .op_last_o(op_last_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_tri_synth.sv
`timescale 1ns/1ps
module tb_tri_synth;
  localparam int MAX_LVL = 16;
  localparam int LVL_W = 5;
  localparam int NUM_W = 26;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ready = 1'b1;
  logic [NUM_W-1:0] num = '0;
  logic [LVL_W-1:0] lvl = '0;
  logic busy, vld, join_t, val_t, last_t, done, err;

  int n_run = 0, n_fail = 0;
  int ops_join [32];
  int ops_val [32];
  int ops_last [32];
  int op_cnt;
  bit saw_err;

  always #4 clk = ~clk;

  tri_synth #(.MAX_LVL(MAX_LVL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .num_i(num), .lvl_i(lvl),
    .busy_o(busy), .op_valid_o(vld), .op_ready_i(ready), .op_join_o(join_t),
    .op_val_o(val_t), .op_last_o(last_t), .done_o(done), .err_o(err)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned p3(int n);
    longint unsigned r = 1;
    for (int i = 0; i < n; i++) r = r * 3;
    return r;
  endfunction

  // drive one request and collect the stream; ready_mode 1 stalls alternate cycles
  task automatic run_req(input longint a, input int n, input int ready_mode, input bit poke);
    int cyc = 0;
    bit stalled = 0;
    int pj = 0, pv = 0, pl = 0;
    op_cnt = 0;
    saw_err = 0;
    @(negedge clk);
    num = NUM_W'(a); lvl = LVL_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 400) begin
      if (poke && cyc == 2) begin
        start = 1'b1; num = NUM_W'(5); lvl = LVL_W'(2);
      end else start = 1'b0;
      if (stalled) begin
        check(vld && join_t == pj && val_t == pv && last_t == pl, "R8 stall hold", vld, 1);
      end
      ready = (ready_mode == 1) ? cyc[0] : 1'b1;
      stalled = vld && !ready;
      pj = join_t; pv = val_t; pl = last_t;
      if (vld && ready && op_cnt < 32) begin
        ops_join[op_cnt] = join_t; ops_val[op_cnt] = val_t; ops_last[op_cnt] = last_t;
        op_cnt++;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    ready = 1'b1;
    saw_err = err;
    check(done && !busy, "R10 done with idle", busy, 0);
    @(negedge clk);
    check(!done, "R10 done pulse width", done, 0);
  endtask

  task automatic good_case(input longint a, input int n, input int ready_mode, input bit poke);
    longint unsigned an = a, num_r, den_r, t;
    int nn = n, k;
    run_req(a, n, ready_mode, poke);
    while (an % 3 == 0) begin an = an / 3; nn--; end
    check(!saw_err, "R9 no error on legal request", saw_err, 0);
    check(op_cnt == nn, "R2 op count equals normalized level", op_cnt, nn);
    if (op_cnt < 1 || op_cnt != nn) return;
    check(ops_last[op_cnt-1] == 1 && ops_join[op_cnt-1] == 0, "R6 base switch flags",
          ops_last[op_cnt-1], 1);
    if (nn == 1) check(ops_val[0] == (an == 2 ? 1 : 0), "R6 base value", ops_val[0], an == 2);
    else begin
      t = p3(nn - 1);
      if (an < t)
        check(ops_join[0] == 0 && ops_val[0] == 0, "R3 below T", ops_join[0]*2+ops_val[0], 0);
      else if (an < 2*t) begin
        if (an % 2 == 1)
          check(ops_join[0] == 1 && ops_val[0] == 0, "R4 middle odd", ops_join[0]*2+ops_val[0], 2);
        else
          check(ops_join[0] == 0 && ops_val[0] == 1, "R4 middle even", ops_join[0]*2+ops_val[0], 1);
      end else
        check(ops_join[0] == 1 && ops_val[0] == 1, "R5 above 2T", ops_join[0]*2+ops_val[0], 3);
    end
    num_r = ops_val[op_cnt-1] ? 2 : 1;
    den_r = 3;
    for (int i = op_cnt - 2; i >= 0; i--) begin
      k = ops_val[i] ? 2 : 1;
      if (ops_join[i] == 0) num_r = num_r * k;
      else num_r = k * den_r + (3 - k) * num_r;
      den_r = den_r * 3;
    end
    check(num_r * p3(n) == longint'(a) * den_r, "R7 exact rebuild",
          longint'(num_r * p3(n)), longint'(a) * den_r);
  endtask

  task automatic err_case(input longint a, input int n);
    run_req(a, n, 0, 0);
    check(saw_err, "R9 error flagged", saw_err, 1);
    check(op_cnt == 0, "R9 no ops on error", op_cnt, 0);
  endtask

  task automatic t_reset;
    check(!busy && !vld && !done && !err, "R1 reset state", {busy, vld, done, err}, 0);
  endtask

  task automatic t_doc_example;
    good_case(40, 4, 0, 0);
    check(ops_join[0]==0 && ops_val[0]==1 && ops_join[1]==1 && ops_val[1]==1 &&
          ops_join[2]==0 && ops_val[2]==0 && ops_val[3]==1, "R4 R5 R3 R6 sequence 40/81",
          ops_join[1], 1);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #20;
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_doc_example();
    good_case(1, 1, 0, 0);
    good_case(2, 1, 1, 0);
    good_case(18, 4, 0, 0);
    good_case(13, 3, 1, 0);
    good_case(14, 3, 0, 0);
    good_case(1, 16, 1, 0);
    good_case(p3(16) - 1, 16, 1, 0);
    good_case(p3(15), 16, 0, 0);
    good_case(40, 4, 0, 1);  // R10 start ignored mid-run
    err_case(0, 3);
    err_case(27, 3);
    err_case(1, 0);
    err_case(1, 17);
    for (int a = 1; a < 81; a++) good_case(a, 4, a % 2, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule